// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the hardware half of taking an interrupt. The arbiter grants one request. In that cycle the block takes a snapshot of the processor status word, the return program counter and the stack pointer. It then stores two words just below the stack top through a single-word write port that waits on a ready handshake. After both stores complete, it pulses three update strobes in turn: the new status word, the lowered stack pointer and the vector address for the program counter.

The status word written back has its interrupt-enable bit cleared. Its mask field carries the level of the granted request. For a non-maskable entry the mask field is passed through unchanged. The block holds busy from the grant until the program counter load, and it ignores further grants while busy.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is high, and whenever busy is low, busy, mem_req, psw_we, sp_we and pc_we are all low.
- R2: A grant (acc_valid high while busy is low) makes busy and mem_req rise in the next cycle. That first store has mem_addr = cur_sp − 8 and mem_wdata = cur_psw zero-extended, using the values sampled in the grant cycle.
- R3: While mem_req is high and mem_ready is low, mem_req, mem_addr and mem_wdata hold their values. A store completes in the cycle in which mem_req and mem_ready are both high.
- R4: The cycle after the first store completes, the second store is presented with mem_addr = sampled SP − 4 and mem_wdata = sampled PC.
- R5: The cycle after the second store completes, psw_we pulses. At that pulse psw_next equals the sampled status word with bit 11 (enable) cleared and bits 10:8 (mask) set to acc_level. All other bits are unchanged.
- R6: For a grant with acc_nmi high, bits 10:8 of psw_next equal those of the sampled status word. Bit 11 is still cleared.
- R7: sp_we pulses in the cycle after psw_we, with sp_next = sampled SP − 8.
- R8: pc_we pulses in the cycle after sp_we, with pc_next = sampled acc_vector. busy is low in the following cycle.
- R9: Changes on cur_psw, cur_pc, cur_sp, acc_level, acc_nmi and acc_vector after the grant cycle do not affect any store or update of that entry.
- R10: acc_valid while busy is high starts no new entry and does not disturb the entry in progress.
- R11: At most one of psw_we, sp_we and pc_we is high in any cycle. Each is high for exactly one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Grant from the arbiter |
| acc_level | input | LVL_W | Level of the granted request |
| acc_nmi | input | 1 | Granted request is non-maskable |
| acc_vector | input | ADDR_W | Handler address for the granted request |
| cur_psw | input | PSW_W | Current status word |
| cur_pc | input | ADDR_W | Return program counter |
| cur_sp | input | ADDR_W | Current stack pointer |
| mem_req | output | 1 | Store request |
| mem_addr | output | ADDR_W | Store address |
| mem_wdata | output | DATA_W | Store data |
| mem_ready | input | 1 | Memory accepts the store |
| psw_we | output | 1 | Status word update strobe |
| psw_next | output | PSW_W | New status word |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_next | output | ADDR_W | New stack pointer |
| pc_we | output | 1 | Program counter load strobe |
| pc_next | output | ADDR_W | New program counter |
| busy | output | 1 | Entry in progress |

## Verification
The bound assertions check every cycle that stores hold still under back-pressure and that the three strobes are mutually exclusive and follow each other in order. They also check that busy covers every store and strobe, and that the enable bit is clear whenever the status word is updated. The addresses, the saved data, the mask value for maskable and non-maskable entries, and immunity to inputs that change mid-entry or to grants that arrive while busy need the reference model. The bench compares it against the outputs every cycle under random wait states and random input churn.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SAVE_PSW = 3'd1,
    ST_SAVE_PC  = 3'd2,
    ST_SET_PSW  = 3'd3,
    ST_SET_SP   = 3'd4,
    ST_SET_PC   = 3'd5
  } entry_state_t;
endpackage

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         acc_valid,
  input  logic         mem_ready,
  output entry_state_t state,
  output logic         capture,
  output logic         advance
);
  entry_state_t state_q, state_d;

  assign state   = state_q;
  assign capture = (state_q == ST_IDLE) && acc_valid;
  assign advance = (state_q == ST_SAVE_PSW) && mem_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (acc_valid) state_d = ST_SAVE_PSW;
      ST_SAVE_PSW: if (mem_ready) state_d = ST_SAVE_PC;
      ST_SAVE_PC:  if (mem_ready) state_d = ST_SET_PSW;
      ST_SET_PSW:  state_d = ST_SET_SP;
      ST_SET_SP:   state_d = ST_SET_PC;
      ST_SET_PC:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/irq_entry_ctx.sv
module irq_entry_ctx #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PSW_W  = 16,
  parameter int LVL_W  = 3,
  parameter int IE_BIT = 11,
  parameter int IM_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              advance,
  input  logic [LVL_W-1:0]  acc_level,
  input  logic              acc_nmi,
  input  logic [ADDR_W-1:0] acc_vector,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_sp,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [PSW_W-1:0]  psw_new,
  output logic [ADDR_W-1:0] sp_new,
  output logic [ADDR_W-1:0] pc_new
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int FRAME_BYTES = 2 * WORD_BYTES;
  localparam int PC_SLOT     = FRAME_BYTES - WORD_BYTES;

  logic [PSW_W-1:0]  psw_mod;
  logic [ADDR_W-1:0] pc_slot_addr;
  logic [ADDR_W-1:0] pc_keep;

  always_comb begin
    psw_mod         = cur_psw;
    psw_mod[IE_BIT] = 1'b0;
    if (!acc_nmi) psw_mod[IM_LSB +: LVL_W] = acc_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr      <= '0;
      wr_data      <= '0;
      psw_new      <= '0;
      sp_new       <= '0;
      pc_new       <= '0;
      pc_slot_addr <= '0;
      pc_keep      <= '0;
    end else if (capture) begin
      wr_addr      <= cur_sp - ADDR_W'(FRAME_BYTES);
      wr_data      <= DATA_W'(cur_psw);
      pc_slot_addr <= cur_sp - ADDR_W'(PC_SLOT);
      pc_keep      <= cur_pc;
      sp_new       <= cur_sp - ADDR_W'(FRAME_BYTES);
      pc_new       <= acc_vector;
      psw_new      <= psw_mod;
    end else if (advance) begin
      wr_addr <= pc_slot_addr;
      wr_data <= DATA_W'(pc_keep);
    end
  end
endmodule

// File: rtl/irq_entry_strb.sv
module irq_entry_strb
  import irq_entry_pkg::*;
(
  input  entry_state_t state,
  output logic         mem_req,
  output logic         psw_we,
  output logic         sp_we,
  output logic         pc_we,
  output logic         busy
);
  assign mem_req = (state == ST_SAVE_PSW) || (state == ST_SAVE_PC);
  assign psw_we  = (state == ST_SET_PSW);
  assign sp_we   = (state == ST_SET_SP);
  assign pc_we   = (state == ST_SET_PC);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PSW_W  = 16,
  parameter int LVL_W  = 3,
  parameter int IE_BIT = 11,
  parameter int IM_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [LVL_W-1:0]  acc_level,
  input  logic              acc_nmi,
  input  logic [ADDR_W-1:0] acc_vector,
  input  logic [PSW_W-1:0]  cur_psw,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_sp,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              psw_we,
  output logic [PSW_W-1:0]  psw_next,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_next,
  output logic              pc_we,
  output logic [ADDR_W-1:0] pc_next,
  output logic              busy
);
  entry_state_t state;
  logic         capture;
  logic         advance;

  irq_entry_fsm i_fsm (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .mem_ready(mem_ready),
    .state(state), .capture(capture), .advance(advance)
  );

  irq_entry_ctx #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSW_W(PSW_W),
    .LVL_W(LVL_W), .IE_BIT(IE_BIT), .IM_LSB(IM_LSB)
  ) i_ctx (
    .clk(clk), .rst(rst), .capture(capture), .advance(advance),
    .acc_level(acc_level), .acc_nmi(acc_nmi), .acc_vector(acc_vector),
    .cur_psw(cur_psw), .cur_pc(cur_pc), .cur_sp(cur_sp),
    .wr_addr(mem_addr), .wr_data(mem_wdata),
    .psw_new(psw_next), .sp_new(sp_next), .pc_new(pc_next)
  );

  irq_entry_strb i_strb (
    .state(state), .mem_req(mem_req), .psw_we(psw_we),
    .sp_we(sp_we), .pc_we(pc_we), .busy(busy)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PSW_W  = 16,
  parameter int IE_BIT = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              psw_we,
  input logic [PSW_W-1:0]  psw_next,
  input logic              sp_we,
  input logic              pc_we,
  input logic              busy
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !psw_we && !sp_we && !pc_we);

  a_r3_hold_store: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

  a_r5_enable_clear: assert property (@(posedge clk) disable iff (rst)
    psw_we |-> !psw_next[IE_BIT]);

  a_r7_sp_after_psw: assert property (@(posedge clk) disable iff (rst)
    psw_we |=> sp_we);

  a_r8_pc_after_sp: assert property (@(posedge clk) disable iff (rst)
    sp_we |=> pc_we);

  a_r8_idle_after_pc: assert property (@(posedge clk) disable iff (rst)
    pc_we |=> !busy);

  a_r10_busy_kept: assert property (@(posedge clk) disable iff (rst)
    busy && !pc_we |=> busy);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({psw_we, sp_we, pc_we}));
endmodule

bind irq_entry_seq irq_entry_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSW_W(PSW_W), .IE_BIT(IE_BIT)
) i_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .psw_we(psw_we),
  .psw_next(psw_next), .sp_we(sp_we), .pc_we(pc_we), .busy(busy)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_level = '0;
  logic        acc_nmi = 1'b0;
  logic [31:0] acc_vector = '0;
  logic [15:0] cur_psw = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] cur_sp = '0;
  logic        mem_ready = 1'b0;
  logic        mem_req, psw_we, sp_we, pc_we, busy;
  logic [31:0] mem_addr, mem_wdata, sp_next, pc_next;
  logic [15:0] psw_next;

  irq_entry_seq i_irq_entry_seq (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_level(acc_level),
    .acc_nmi(acc_nmi), .acc_vector(acc_vector), .cur_psw(cur_psw),
    .cur_pc(cur_pc), .cur_sp(cur_sp), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .psw_we(psw_we),
    .psw_next(psw_next), .sp_we(sp_we), .sp_next(sp_next), .pc_we(pc_we),
    .pc_next(pc_next), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int entries = 0;
  int psw_pulses = 0;
  int sp_pulses = 0;
  int pc_pulses = 0;
  bit done = 1'b0;

  // reference model: phase counter and snapshot
  int          ph = 0;
  logic [15:0] m_psw;
  logic [31:0] m_pc, m_sp, m_vec;
  logic [2:0]  m_lvl;
  logic        m_nmi;
  logic [31:0] m_wr_q[$];

  function automatic logic [15:0] exp_psw();
    logic [15:0] p;
    p = m_psw;
    p[11] = 1'b0;               // R5 enable bit 11 cleared
    if (!m_nmi) p[10:8] = m_lvl; // R6 keeps 10:8 for non-maskable
    return p;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      ph = 0;
      m_wr_q.delete();
    end else begin
      case (ph)
        0: if (acc_valid) begin
             m_psw = cur_psw; m_pc = cur_pc; m_sp = cur_sp;
             m_vec = acc_vector; m_lvl = acc_level; m_nmi = acc_nmi;
             m_wr_q.push_back(cur_sp - 32'd8);
             m_wr_q.push_back({16'd0, cur_psw});
             m_wr_q.push_back(cur_sp - 32'd4);
             m_wr_q.push_back(cur_pc);
             entries++;
             ph = 1;
           end
        1, 2: if (mem_ready) begin
             void'(m_wr_q.pop_front());
             void'(m_wr_q.pop_front());
             ph = ph + 1;
           end
        5: ph = 0;
        default: ph = ph + 1;
      endcase
    end
  end

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(int p);
    case (p)
      0: return rst ? "R1" : "R10";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      string t;
      t = tag_of(ph);
      chk(busy == (ph != 0), t, "busy", busy, ph != 0);
      chk(mem_req == (ph == 1 || ph == 2), t, "mem_req", mem_req, ph == 1 || ph == 2);
      chk(psw_we == (ph == 3), "R11", "psw_we", psw_we, ph == 3);
      chk(sp_we == (ph == 4), "R11", "sp_we", sp_we, ph == 4);
      chk(pc_we == (ph == 5), "R11", "pc_we", pc_we, ph == 5);
      if ((ph == 1 || ph == 2) && m_wr_q.size() >= 2) begin
        // R3 and R9: values stay those of the grant, whatever inputs do
        chk(mem_addr == m_wr_q[0], t, "mem_addr", mem_addr, m_wr_q[0]);
        chk(mem_wdata == m_wr_q[1], t, "mem_wdata", mem_wdata, m_wr_q[1]);
      end
      if (ph == 3)
        chk(psw_next == exp_psw(), m_nmi ? "R6" : "R5", "psw_next", psw_next, exp_psw());
      if (ph == 4) chk(sp_next == m_sp - 32'd8, "R7", "sp_next", sp_next, m_sp - 32'd8);
      if (ph == 5) chk(pc_next == m_vec, "R8", "pc_next", pc_next, m_vec);
      if (psw_we) psw_pulses++;
      if (sp_we)  sp_pulses++;
      if (pc_we)  pc_pulses++;
    end
  end

  task automatic churn(int valid_pct, int ready_pct);
    acc_valid  = ($urandom % 100) < valid_pct;
    acc_level  = 3'($urandom);
    acc_nmi    = ($urandom % 5) == 0;
    acc_vector = $urandom;
    cur_psw    = 16'($urandom);
    cur_pc     = $urandom;
    cur_sp     = $urandom;
    mem_ready  = ($urandom % 100) < ready_pct;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state already compared each cycle; an explicit one more:
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset", {busy, mem_req}, 0);
    // zero-wait memory, sparse grants
    for (int i = 0; i < 400; i++) begin @(negedge clk); churn(30, 100); end
    // heavy back-pressure (R3) with input churn (R9)
    for (int i = 0; i < 1500; i++) begin @(negedge clk); churn(40, 35); end
    // grants held high continuously: R10, ignored while busy
    for (int i = 0; i < 600; i++) begin @(negedge clk); churn(100, 60); end
    // drain
    for (int i = 0; i < 200; i++) begin @(negedge clk); churn(0, 100); end
    @(negedge clk);
    done = 1'b1;
    chk(entries > 50, "R11", "entries seen", entries, 51);
    chk(psw_pulses == entries, "R11", "psw_we pulses", psw_pulses, entries);
    chk(sp_pulses == entries, "R11", "sp_we pulses", sp_pulses, entries);
    chk(pc_pulses == entries, "R11", "pc_we pulses", pc_pulses, entries);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule